// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller

This block keeps one small direct-mapped, single-word-per-line cache coherent with its peers on a shared snooping bus. Every line holds a tag, one data word and a coherence state: Modified, Shared or Invalid. The processor side issues reads and writes. The controller either completes them locally or asks for the bus, which it needs to fetch a line, to gain ownership, or to write back a dirty victim.

At the same time the controller watches every transaction that another cache places on the bus. It drops its copy when another cache writes the line. When it owns the only current copy, it hands that copy out, and the memory model captures the word as the block goes by. Each granted transaction takes effect at the clock edge that ends its grant cycle. Arbitration between caches and the memory model live outside the block.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_done_o`, `bus_req_o` and `snp_supply_o` are low, and the first access to any address goes to the bus.
- R2: A read whose tag matches a Shared or Modified line returns the cached word with `cpu_done_o` high one cycle after the request is seen, and issues no bus command.
- R3: A read miss issues bus command 1 (read miss) at the request address. It takes the word on `bus_rdata_i` in the grant cycle, returns it, and leaves the line Shared.
- R4: On a miss where the indexed line is Modified with a different tag, the controller first issues command 4 (writeback) with the victim's address, built as {old tag, index}, and its data. The line goes Invalid and the miss is then issued. A Shared victim is dropped with no bus command.
- R5: A write to a Shared line with a matching tag issues command 3 (upgrade) and leaves the line Modified with the new word. A write to a Modified line with a matching tag completes with no bus command.
- R6: A write miss issues command 2 (write miss) and leaves the line Modified with the written word.
- R7: A snooped read miss (command 1) to a line held Shared leaves `snp_supply_o` low and does not change the line.
- R8: A snooped read miss to a line held Modified raises `snp_supply_o` with the line's word on `snp_data_o` in that cycle, and the line becomes Shared.
- R9: A snooped write miss or upgrade (command 2 or 3) to a line held Shared or Modified makes it Invalid. A Modified line also raises `snp_supply_o` with its word in that cycle.
- R10: A request needing the bus holds `bus_req_o`, `bus_cmd_o` and `bus_addr_o` steady, with `cpu_done_o` low, until `bus_gnt_i`. `cpu_done_o` is a one-cycle pulse in the cycle after completion, and the request must drop in that cycle.
- R11: A snoop to the same index as a pending local request wins in that cycle, and the local request cannot complete in that cycle. A request whose line was invalidated while it waited is evaluated again as a miss.

Address layout: index = low log2(LINES) bits of the address, tag = the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Word address |
| cpu_wdata_i | input | DW | Write data |
| cpu_rdata_o | output | DW | Read data, valid with done |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; transaction takes effect at the edge ending this cycle |
| bus_cmd_o | output | 3 | 1 read miss, 2 write miss, 3 upgrade, 4 writeback |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Writeback data |
| bus_rdata_i | input | DW | Fill data in the grant cycle |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 3 | Snooped command, same encoding |
| snp_addr_i | input | AW | Snooped address |
| snp_supply_o | output | 1 | This cache supplies the block |
| snp_data_o | output | DW | Supplied block |

## Verification
A wrong line state shows at the ports as a wrong command choice on the next access to that index. A stale Shared line gives a read hit where a miss should go to the bus. A lost Modified state gives an upgrade where a completion without the bus is expected. A missed invalidation leaves a peer reading old data. These faults appear only at that next access, so the bench touches every line again after each transition: it checks the command sequence each cache places on the bus, the data each cache returns, and the words that supply and writeback deposit in memory. The bench runs two instances over a shared memory and traces their states through Shared, Modified, supply, conflict writeback and a write race between them.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_UPGR   = 3'd3,
    BC_WBACK  = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TW    = 6,
  parameter int DW    = 32,
  localparam int IW   = $clog2(LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   la_idx_i,
  output line_st_e        la_st_o,
  output logic [TW-1:0]   la_tag_o,
  output logic [DW-1:0]   la_data_o,
  input  logic [IW-1:0]   sa_idx_i,
  output line_st_e        sa_st_o,
  output logic [TW-1:0]   sa_tag_o,
  output logic [DW-1:0]   sa_data_o,
  input  logic            lw_en_i,
  input  logic [IW-1:0]   lw_idx_i,
  input  line_st_e        lw_st_i,
  input  logic [TW-1:0]   lw_tag_i,
  input  logic [DW-1:0]   lw_data_i,
  input  logic            sw_en_i,
  input  logic [IW-1:0]   sw_idx_i,
  input  line_st_e        sw_st_i
);
  line_st_e      st_q   [LINES];
  logic [TW-1:0] tag_q  [LINES];
  logic [DW-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (lw_en_i && lw_idx_i == IW'(i)) begin
          st_q[i]   <= lw_st_i;
          tag_q[i]  <= lw_tag_i;
          data_q[i] <= lw_data_i;
        end
        // snoop update wins on the state field
        if (sw_en_i && sw_idx_i == IW'(i)) st_q[i] <= sw_st_i;
      end
    end
  end

  assign la_st_o   = st_q[la_idx_i];
  assign la_tag_o  = tag_q[la_idx_i];
  assign la_data_o = data_q[la_idx_i];
  assign sa_st_o   = st_q[sa_idx_i];
  assign sa_tag_o  = tag_q[sa_idx_i];
  assign sa_data_o = data_q[sa_idx_i];
endmodule

// File: rtl/msi_snoop.sv
`timescale 1ns/1ps
module msi_snoop
  import msi_pkg::*;
#(
  parameter int TW = 6,
  parameter int DW = 32
) (
  input  logic          snp_valid_i,
  input  logic [2:0]    snp_cmd_i,
  input  logic [TW-1:0] snp_tag_i,
  input  line_st_e      line_st_i,
  input  logic [TW-1:0] line_tag_i,
  input  logic [DW-1:0] line_data_i,
  output logic          sw_en_o,
  output line_st_e      sw_st_o,
  output logic          supply_o,
  output logic [DW-1:0] supply_data_o
);
  logic hit;
  assign hit           = snp_valid_i && line_st_i != ST_I && line_tag_i == snp_tag_i;
  assign supply_data_o = line_data_i;

  always_comb begin
    sw_en_o  = 1'b0;
    sw_st_o  = line_st_i;
    supply_o = 1'b0;
    if (hit) begin
      unique case (bus_cmd_e'(snp_cmd_i))
        BC_RDMISS: if (line_st_i == ST_M) begin
          supply_o = 1'b1;
          sw_en_o  = 1'b1;
          sw_st_o  = ST_S;
        end
        BC_WRMISS, BC_UPGR: begin
          supply_o = (line_st_i == ST_M);
          sw_en_o  = 1'b1;
          sw_st_o  = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_local.sv
`timescale 1ns/1ps
module msi_local
  import msi_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 2,
  localparam int TW = AW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  line_st_e      line_st_i,
  input  logic [TW-1:0] line_tag_i,
  input  logic [DW-1:0] line_data_i,
  input  logic          snp_block_i,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o,
  output bus_cmd_e      bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          lw_en_o,
  output line_st_e      lw_st_o,
  output logic [TW-1:0] lw_tag_o,
  output logic [DW-1:0] lw_data_o,
  output logic          cpu_done_o,
  output logic [DW-1:0] cpu_rdata_o
);
  logic          done_q, act, tag_hit, dirty_victim, fin;
  logic [DW-1:0] fin_data, rdata_q;
  logic [TW-1:0] req_tag;

  assign req_tag      = cpu_addr_i[AW-1:IW];
  assign act          = cpu_req_i && !done_q;
  assign tag_hit      = line_st_i != ST_I && line_tag_i == req_tag;
  assign dirty_victim = line_st_i == ST_M && line_tag_i != req_tag;
  assign bus_wdata_o  = line_data_i;

  always_comb begin
    bus_req_o  = 1'b0;
    bus_cmd_o  = BC_NONE;
    bus_addr_o = cpu_addr_i;
    lw_en_o    = 1'b0;
    lw_st_o    = line_st_i;
    lw_tag_o   = line_tag_i;
    lw_data_o  = line_data_i;
    fin        = 1'b0;
    fin_data   = line_data_i;
    if (act) begin
      if (tag_hit && (!cpu_we_i || line_st_i == ST_M)) begin
        if (!snp_block_i) begin
          fin = 1'b1;
          if (cpu_we_i) begin
            fin_data  = cpu_wdata_i;
            lw_en_o   = 1'b1;
            lw_data_o = cpu_wdata_i;
          end
        end
      end else begin
        bus_req_o = 1'b1;
        if (dirty_victim) begin
          bus_cmd_o  = BC_WBACK;
          bus_addr_o = {line_tag_i, cpu_addr_i[IW-1:0]};
        end else if (cpu_we_i) bus_cmd_o = tag_hit ? BC_UPGR : BC_WRMISS;
        else bus_cmd_o = BC_RDMISS;
        if (bus_gnt_i) begin
          lw_en_o = 1'b1;
          if (dirty_victim) lw_st_o = ST_I;
          else begin
            fin      = 1'b1;
            lw_tag_o = req_tag;
            if (cpu_we_i) begin
              lw_st_o   = ST_M;
              lw_data_o = cpu_wdata_i;
              fin_data  = cpu_wdata_i;
            end else begin
              lw_st_o   = ST_S;
              lw_data_o = bus_rdata_i;
              fin_data  = bus_rdata_i;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= fin;
      if (fin) rdata_q <= fin_data;
    end
  end

  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/msi_cache_ctrl.sv
`timescale 1ns/1ps
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_done_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [2:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          snp_valid_i,
  input  logic [2:0]    snp_cmd_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_supply_o,
  output logic [DW-1:0] snp_data_o
);
  line_st_e      la_st, sa_st, lw_st, sw_st;
  logic [TW-1:0] la_tag, sa_tag, lw_tag;
  logic [DW-1:0] la_data, sa_data, lw_data;
  logic          lw_en, sw_en, snp_block;
  bus_cmd_e      cmd;

  // a snoop on the same index freezes local completion for that cycle
  assign snp_block = snp_valid_i && snp_addr_i[IW-1:0] == cpu_addr_i[IW-1:0];
  assign bus_cmd_o = cmd;

  msi_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .la_idx_i(cpu_addr_i[IW-1:0]), .la_st_o(la_st), .la_tag_o(la_tag), .la_data_o(la_data),
    .sa_idx_i(snp_addr_i[IW-1:0]), .sa_st_o(sa_st), .sa_tag_o(sa_tag), .sa_data_o(sa_data),
    .lw_en_i(lw_en), .lw_idx_i(cpu_addr_i[IW-1:0]), .lw_st_i(lw_st), .lw_tag_i(lw_tag),
    .lw_data_i(lw_data),
    .sw_en_i(sw_en), .sw_idx_i(snp_addr_i[IW-1:0]), .sw_st_i(sw_st)
  );

  msi_snoop #(.TW(TW), .DW(DW)) u_snoop (
    .snp_valid_i, .snp_cmd_i, .snp_tag_i(snp_addr_i[AW-1:IW]),
    .line_st_i(sa_st), .line_tag_i(sa_tag), .line_data_i(sa_data),
    .sw_en_o(sw_en), .sw_st_o(sw_st), .supply_o(snp_supply_o), .supply_data_o(snp_data_o)
  );

  msi_local #(.AW(AW), .DW(DW), .IW(IW)) u_local (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .line_st_i(la_st), .line_tag_i(la_tag), .line_data_i(la_data),
    .snp_block_i(snp_block), .bus_gnt_i, .bus_rdata_i,
    .bus_req_o, .bus_cmd_o(cmd), .bus_addr_o, .bus_wdata_o,
    .lw_en_o(lw_en), .lw_st_o(lw_st), .lw_tag_o(lw_tag), .lw_data_o(lw_data),
    .cpu_done_o, .cpu_rdata_o
  );
endmodule

// File: rtl/msi_cache_chk.sv
`timescale 1ns/1ps
module msi_cache_chk #(
  parameter int AW    = 8,
  parameter int LINES = 4,
  localparam int IW   = $clog2(LINES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_req_i,
  input logic [AW-1:0] cpu_addr_i,
  input logic          cpu_done_o,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic [2:0]    bus_cmd_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          snp_valid_i,
  input logic [2:0]    snp_cmd_i,
  input logic [AW-1:0] snp_addr_i,
  input logic          snp_supply_o
);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  a_r10_req_needs_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> cpu_req_i && !cpu_done_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i && !snp_valid_i && cpu_req_i
    |=> !cpu_req_i || (bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)));

  a_r4_wb_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_cmd_o == 3'd4
    |=> !cpu_req_i || (bus_req_o && bus_cmd_o != 3'd4 && !cpu_done_o));

  a_r9_supply_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_valid_i && (snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2));

  a_r8_owner_supplies_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |=> !(snp_supply_o && $stable(snp_addr_i)));

  a_r11_snoop_blocks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && cpu_req_i && !bus_gnt_i
    && snp_addr_i[IW-1:0] == cpu_addr_i[IW-1:0] |=> !cpu_done_o);
endmodule

bind msi_cache_ctrl msi_cache_chk #(.AW(AW), .LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i),
  .cpu_done_o(cpu_done_o), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .snp_valid_i(snp_valid_i),
  .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i), .snp_supply_o(snp_supply_o)
);

// File: tb/sim_msi_cache_ctrl.sv
`timescale 1ns/1ps
module sim_msi_cache_ctrl;
  localparam logic [7:0] XA = 8'h10, YA = 8'h20, ZA = 8'h05;

  logic clk_i = 1'b0, rst_ni = 1'b0, hold_a = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        creq [2];
  logic        cwe  [2];
  logic [7:0]  cad  [2];
  logic [31:0] cwd  [2];
  logic        cdone[2];
  logic [31:0] crd  [2];

  logic        bq_a, bq_b, gn_a, gn_b, sup_a, sup_b;
  logic [2:0]  bc_a, bc_b;
  logic [7:0]  ba_a, ba_b;
  logic [31:0] bw_a, bw_b, brd_a, brd_b, sd_a, sd_b;
  logic [31:0] mem [256];

  assign gn_a  = bq_a && !hold_a;
  assign gn_b  = bq_b && !gn_a;
  assign brd_a = sup_b ? sd_b : mem[ba_a];
  assign brd_b = sup_a ? sd_a : mem[ba_b];

  msi_cache_ctrl u0 (
    .clk_i, .rst_ni, .cpu_req_i(creq[0]), .cpu_we_i(cwe[0]), .cpu_addr_i(cad[0]),
    .cpu_wdata_i(cwd[0]), .cpu_rdata_o(crd[0]), .cpu_done_o(cdone[0]),
    .bus_req_o(bq_a), .bus_gnt_i(gn_a), .bus_cmd_o(bc_a), .bus_addr_o(ba_a),
    .bus_wdata_o(bw_a), .bus_rdata_i(brd_a), .snp_valid_i(gn_b), .snp_cmd_i(bc_b),
    .snp_addr_i(ba_b), .snp_supply_o(sup_a), .snp_data_o(sd_a));

  msi_cache_ctrl u1 (
    .clk_i, .rst_ni, .cpu_req_i(creq[1]), .cpu_we_i(cwe[1]), .cpu_addr_i(cad[1]),
    .cpu_wdata_i(cwd[1]), .cpu_rdata_o(crd[1]), .cpu_done_o(cdone[1]),
    .bus_req_o(bq_b), .bus_gnt_i(gn_b), .bus_cmd_o(bc_b), .bus_addr_o(ba_b),
    .bus_wdata_o(bw_b), .bus_rdata_i(brd_b), .snp_valid_i(gn_a), .snp_cmd_i(bc_a),
    .snp_addr_i(ba_a), .snp_supply_o(sup_b), .snp_data_o(sd_b));

  int       n_chk = 0, n_bad = 0;
  int       nlog [2];
  logic [2:0] logq [2][4];
  int       sup_cnt [2];
  logic [31:0] rd0, rd1;
  int       lat0, lat1;

  // memory model and bus monitor
  always @(posedge clk_i) begin
    if (gn_a) begin
      if (bc_a == 3'd4) mem[ba_a] <= bw_a;
      else if (sup_b) mem[ba_a] <= sd_b;
      if (nlog[0] < 4) logq[0][nlog[0]] = bc_a;
      nlog[0]++;
    end
    if (gn_b) begin
      if (bc_b == 3'd4) mem[ba_b] <= bw_b;
      else if (sup_a) mem[ba_b] <= sd_a;
      if (nlog[1] < 4) logq[1][nlog[1]] = bc_b;
      nlog[1]++;
    end
    if (sup_a) sup_cnt[0]++;
    if (sup_b) sup_cnt[1]++;
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic chk_log(input int c, input string r, input int n,
                         input logic [2:0] c0, input logic [2:0] c1);
    chk({r, " bus cmd count"}, 32'(nlog[c]), 32'(n));
    if (n > 0) chk({r, " first cmd"}, 32'(logq[c][0]), 32'(c0));
    if (n > 1) chk({r, " second cmd"}, 32'(logq[c][1]), 32'(c1));
  endtask

  task automatic run_op(input int c, input bit we, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk_i);
    nlog[c] = 0;
    creq[c] = 1'b1; cwe[c] = we; cad[c] = a; cwd[c] = wd;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!cdone[c] && lat < 500);
    rd = crd[c];
    creq[c] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done low A", 32'(cdone[0]), 0);
    chk("R1 bus_req low B", 32'(bq_b), 0);
    chk("R1 supply low", 32'(sup_a | sup_b), 0);
    run_op(0, 0, XA, 0, rd0, lat0);
    chk_log(0, "R1 R3 cold read A", 1, 3'd1, 3'd0);
    chk("R3 fill data", rd0, mem[XA]);
    chk("R3 latency", 32'(lat0), 1);
  endtask

  task automatic t_share;
    int s = sup_cnt[0];
    run_op(1, 0, XA, 0, rd1, lat1);
    chk_log(1, "R3 read B", 1, 3'd1, 3'd0);
    chk("R7 shared holder silent", 32'(sup_cnt[0] - s), 0);
    chk("R3 data B", rd1, 32'hC0DE_0010);
    run_op(0, 0, XA, 0, rd0, lat0);
    chk_log(0, "R2 R7 read hit A", 0, 3'd0, 3'd0);
    chk("R2 hit data", rd0, 32'hC0DE_0010);
    chk("R2 hit latency", 32'(lat0), 1);
  endtask

  task automatic t_upgrade_supply;
    run_op(0, 1, XA, 32'h1111_0001, rd0, lat0);
    chk_log(0, "R5 upgrade", 1, 3'd3, 3'd0);
    run_op(0, 1, XA, 32'h1111_0002, rd0, lat0);
    chk_log(0, "R5 write hit M", 0, 3'd0, 3'd0);
    run_op(1, 0, XA, 0, rd1, lat1);
    chk_log(1, "R9 B invalidated by upgrade", 1, 3'd1, 3'd0);
    chk("R8 owner supplied data", rd1, 32'h1111_0002);
    chk("R8 memory updated", mem[XA], 32'h1111_0002);
    run_op(0, 1, XA, 32'h1111_0003, rd0, lat0);
    chk_log(0, "R8 owner left Shared", 1, 3'd3, 3'd0);
  endtask

  task automatic t_write_miss;
    run_op(1, 1, XA, 32'h2222_0004, rd1, lat1);
    chk_log(1, "R6 write miss B", 1, 3'd2, 3'd0);
    chk("R9 M supply to memory", mem[XA], 32'h1111_0003);
    run_op(0, 0, XA, 0, rd0, lat0);
    chk_log(0, "R9 A invalidated by write miss", 1, 3'd1, 3'd0);
    chk("R8 data from B", rd0, 32'h2222_0004);
  endtask

  task automatic t_conflict;
    run_op(1, 1, YA, 32'h3333_0005, rd1, lat1);
    chk_log(1, "R4 Shared victim silent", 1, 3'd2, 3'd0);
    chk("R4 memory Y untouched", mem[YA], 32'hC0DE_0020);
    run_op(1, 0, XA, 0, rd1, lat1);
    chk_log(1, "R4 dirty victim writeback", 2, 3'd4, 3'd1);
    chk("R4 writeback data", mem[YA], 32'h3333_0005);
    chk("R4 read after writeback", rd1, 32'h2222_0004);
    chk("R4 latency two grants", 32'(lat1), 2);
  endtask

  task automatic t_race;
    fork
      run_op(0, 1, XA, 32'h4444_0006, rd0, lat0);
      run_op(1, 1, XA, 32'h4444_0007, rd1, lat1);
    join
    chk_log(0, "R11 winner upgrades", 1, 3'd3, 3'd0);
    chk_log(1, "R11 loser re-evaluated as write miss", 1, 3'd2, 3'd0);
    chk("R11 loser latency", 32'(lat1), 2);
    chk("R9 winner supplied", mem[XA], 32'h4444_0006);
    run_op(0, 0, XA, 0, rd0, lat0);
    chk_log(0, "R9 winner invalidated", 1, 3'd1, 3'd0);
    chk("R11 final data", rd0, 32'h4444_0007);
  endtask

  task automatic t_other_index;
    run_op(0, 1, ZA, 32'h5555_0008, rd0, lat0);
    chk_log(0, "R6 write miss idx1", 1, 3'd2, 3'd0);
    run_op(0, 0, ZA, 0, rd0, lat0);
    chk_log(0, "R2 read hit M", 0, 3'd0, 3'd0);
    chk("R2 data from M", rd0, 32'h5555_0008);
  endtask

  task automatic t_stall;
    @(negedge clk_i);
    hold_a = 1'b1;
    nlog[0] = 0;
    creq[0] = 1'b1; cwe[0] = 1'b0; cad[0] = YA; cwd[0] = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk("R10 done held low", 32'(cdone[0]), 0);
      chk("R10 request held", 32'(bq_a), 1);
      chk("R10 cmd held", 32'(bc_a), 1);
      chk("R10 addr held", 32'(ba_a), 32'(YA));
    end
    hold_a = 1'b0;
    lat0 = 0;
    do begin
      @(negedge clk_i);
      lat0++;
    end while (!cdone[0] && lat0 < 500);
    creq[0] = 1'b0;
    chk("R10 done after grant", 32'(lat0), 1);
    chk("R10 stalled read data", crd[0], 32'h3333_0005);
    @(negedge clk_i);
    chk("R10 done is a pulse", 32'(cdone[0]), 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'hC0DE_0000 | 32'(a);
    for (int c = 0; c < 2; c++) begin
      creq[c] = 0; cwe[c] = 0; cad[c] = 0; cwd[c] = 0; nlog[c] = 0; sup_cnt[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_share();
    t_upgrade_supply();
    t_write_miss();
    t_conflict();
    t_race();
    t_other_index();
    t_stall();
    repeat (2) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule